// File: doc/BRIEF.md
# Row-Banked Lane Operand Exchange

This block hands each lane of a 64-lane wavefront a 32-bit operand taken from some other lane. The lanes are arranged as four rows of sixteen, and each row is cut into four banks of four lanes. A sharing pattern is chosen on every transfer, and each pattern picks a source lane for each destination lane. The patterns are:

- a permute inside every group of four lanes;
- mirrors over a full row or over a half row;
- shifts and a rotate that stay inside a row;
- one-lane shifts and rotates across the whole wave;
- two broadcasts that carry one lane into later rows.

A row mask and a bank mask decide which destination lanes may be written. A boundary switch decides what a lane gets when its source lies outside the pattern's reach.

A transfer arrives as a valid/ready beat. The beat carries the source operands, the current destination values, the pattern code, its argument, both masks and the boundary switch. The result leaves one cycle later through a single output register that follows valid/ready. The input is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the output holds both its valid flag and its data.

Top module: `lane_share_net`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Mode 0 (group permute): destination lane L takes source lane (L with its two low bits cleared) + arg[2k+1:2k], where k = L mod 4. Every source is valid.
- R3: Mode 8 (row mirror) gives lane p of a row the source at position 15-p of the same row. Mode 9 (half mirror) gives lane p the source at position 7-(p mod 8) inside its own 8-lane half.
- R4: Let n = arg[3:0]. Only row position p (0..15) matters here, and arg[7:4] is ignored.
  - Mode 1 (row shift left) reads position p+n. The source is invalid when p+n > 15.
  - Mode 2 (row shift right) reads position p-n. The source is invalid when p-n < 0.
  - Mode 3 (row rotate right) reads position (p-n) mod 16.
  - n = 0 copies each lane straight across.
- R5: Across the whole wave, lane L reads:
  - Mode 4 (wave shift left): lane L+1, invalid for lane 63.
  - Mode 5 (wave rotate left): lane (L+1) mod 64.
  - Mode 6 (wave shift right): lane L-1, invalid for lane 0.
  - Mode 7 (wave rotate right): lane (L-1) mod 64.
- R6: Mode 10 gives every lane of row r ≥ 1 the source at lane 16r-1, and row 0 has no valid source. Mode 11 gives every lane of rows 2 and 3 the source at lane 31, and rows 0 and 1 have no valid source.
- R7: A lane is enabled when `row_mask[L/16]` and `bank_mask[(L mod 16)/4]` are both 1. A disabled lane outputs its `dst_old` word.
- R8: An enabled lane with an invalid source outputs 0 when `bound_zero` is 1 and its `dst_old` word when it is 0. Modes 12 to 15 are reserved, and every source is invalid under them.
- R9: The result of an accepted beat appears on `out_data` with `out_valid` high in the cycle after acceptance. While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be taken |
| src_data | input | 2048 | Source operand of each lane, lane L at bits [32L+31:32L] |
| dst_old | input | 2048 | Current destination value of each lane, same layout |
| share_mode | input | 4 | Sharing pattern code |
| share_arg | input | 8 | Pattern argument (permute selectors or amount) |
| row_mask | input | 4 | Row write enables, bit r for row r |
| bank_mask | input | 4 | Bank write enables, bit b for bank b |
| bound_zero | input | 1 | Invalid source returns zero when 1 |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat taken downstream |
| out_data | output | 2048 | Resulting destination value of each lane |

## Verification
The bench aims at the edges of the row-bounded patterns:

- A shift of 15 leaves exactly one lane valid per row. A design that let the shift cross into the next row would write data from the wrong row there.
- The wave shifts are checked at lanes 0 and 63. A design that wrapped on a shift, or failed to wrap on a rotate, would show it at one of these lanes.
- The broadcasts are run with the boundary switch on, so the rows with no source must come out as zero rather than stale data.
- Mixed row and bank masks catch a swapped or misdecoded mask bit.
- A stall with a second beat waiting catches an output register that is overwritten while downstream holds off.

// File: rtl/lsn_pkg.sv
package lsn_pkg;
  typedef enum logic [3:0] {
    SM_QPERM   = 4'd0,
    SM_ROW_SHL = 4'd1,
    SM_ROW_SHR = 4'd2,
    SM_ROW_ROR = 4'd3,
    SM_WV_SHL  = 4'd4,
    SM_WV_ROL  = 4'd5,
    SM_WV_SHR  = 4'd6,
    SM_WV_ROR  = 4'd7,
    SM_MIRROR  = 4'd8,
    SM_HMIRROR = 4'd9,
    SM_BC_ROW  = 4'd10,
    SM_BC_HALF = 4'd11
  } share_mode_e;
endpackage

// File: rtl/lsn_src_decode.sv
module lsn_src_decode #(
  parameter int LANES     = 64,
  parameter int ROW_LANES = 16,
  parameter int IDX_W     = 6
) (
  input  logic [3:0]             mode,
  input  logic [7:0]             arg,
  output logic [LANES*IDX_W-1:0] src_idx,
  output logic [LANES-1:0]       src_ok
);
  import lsn_pkg::*;
  localparam int HALF = ROW_LANES / 2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int ROW = g / ROW_LANES;
    localparam int POS = g % ROW_LANES;
    localparam int QP  = g % 4;
    int t;
    logic ok;
    int amt;

    always_comb begin
      amt = int'(arg[3:0]);
      t   = g;
      ok  = 1'b1;
      case (share_mode_e'(mode))
        SM_QPERM:   t = (g - QP) + int'(arg[2*QP +: 2]);
        SM_ROW_SHL: begin
          ok = (POS + amt) < ROW_LANES;
          t  = ok ? g + amt : g;
        end
        SM_ROW_SHR: begin
          ok = (POS - amt) >= 0;
          t  = ok ? g - amt : g;
        end
        SM_ROW_ROR: t = ROW * ROW_LANES + ((POS - amt + ROW_LANES) % ROW_LANES);
        SM_WV_SHL: begin
          ok = (g + 1) < LANES;
          t  = ok ? g + 1 : g;
        end
        SM_WV_ROL:  t = (g + 1) % LANES;
        SM_WV_SHR: begin
          ok = g > 0;
          t  = ok ? g - 1 : g;
        end
        SM_WV_ROR:  t = (g - 1 + LANES) % LANES;
        SM_MIRROR:  t = ROW * ROW_LANES + (ROW_LANES - 1 - POS);
        SM_HMIRROR: t = (g - (POS % HALF)) + (HALF - 1 - (POS % HALF));
        SM_BC_ROW: begin
          ok = ROW >= 1;
          t  = ok ? ROW * ROW_LANES - 1 : g;
        end
        SM_BC_HALF: begin
          ok = ROW >= 2;
          t  = ok ? 2 * ROW_LANES - 1 : g;
        end
        default:    ok = 1'b0;
      endcase
    end

    assign src_idx[g*IDX_W +: IDX_W] = IDX_W'(t);
    assign src_ok[g] = ok;
  end
endmodule

// File: rtl/lsn_lane_select.sv
module lsn_lane_select #(
  parameter int LANES  = 64,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic [LANES*DATA_W-1:0] src_data,
  input  logic [LANES*IDX_W-1:0]  src_idx,
  output logic [LANES*DATA_W-1:0] picked
);
  logic [DATA_W-1:0] words [LANES];

  for (genvar w = 0; w < LANES; w++) begin : g_unpack
    assign words[w] = src_data[w*DATA_W +: DATA_W];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_pick
    assign picked[g*DATA_W +: DATA_W] = words[src_idx[g*IDX_W +: IDX_W]];
  end
endmodule

// File: rtl/lsn_lane_gate.sv
module lsn_lane_gate #(
  parameter int LANES      = 64,
  parameter int DATA_W     = 32,
  parameter int ROW_LANES  = 16,
  parameter int BANK_LANES = 4,
  parameter int ROWS       = LANES / ROW_LANES,
  parameter int BANKS      = ROW_LANES / BANK_LANES
) (
  input  logic [LANES*DATA_W-1:0] picked,
  input  logic [LANES*DATA_W-1:0] dst_old,
  input  logic [LANES-1:0]        src_ok,
  input  logic [ROWS-1:0]         row_mask,
  input  logic [BANKS-1:0]        bank_mask,
  input  logic                    bound_zero,
  output logic [LANES*DATA_W-1:0] result
);
  for (genvar g = 0; g < LANES; g++) begin : g_gate
    localparam int ROW  = g / ROW_LANES;
    localparam int BANK = (g % ROW_LANES) / BANK_LANES;
    logic en;
    logic [DATA_W-1:0] keep;

    assign en   = row_mask[ROW] & bank_mask[BANK];
    assign keep = dst_old[g*DATA_W +: DATA_W];

    always_comb begin
      if (!en)            result[g*DATA_W +: DATA_W] = keep;
      else if (src_ok[g]) result[g*DATA_W +: DATA_W] = picked[g*DATA_W +: DATA_W];
      else if (bound_zero) result[g*DATA_W +: DATA_W] = '0;
      else                result[g*DATA_W +: DATA_W] = keep;
    end
  end
endmodule

// File: rtl/lane_share_net.sv
module lane_share_net #(
  parameter int LANES      = 64,
  parameter int DATA_W     = 32,
  parameter int ROW_LANES  = 16,
  parameter int BANK_LANES = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [LANES*DATA_W-1:0]        src_data,
  input  logic [LANES*DATA_W-1:0]        dst_old,
  input  logic [3:0]                     share_mode,
  input  logic [7:0]                     share_arg,
  input  logic [LANES/ROW_LANES-1:0]     row_mask,
  input  logic [ROW_LANES/BANK_LANES-1:0] bank_mask,
  input  logic                           bound_zero,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [LANES*DATA_W-1:0]        out_data
);
  localparam int IDX_W = $clog2(LANES);
  localparam int ROWS  = LANES / ROW_LANES;
  localparam int BANKS = ROW_LANES / BANK_LANES;

  logic [LANES*IDX_W-1:0]  src_idx;
  logic [LANES-1:0]        src_ok;
  logic [LANES*DATA_W-1:0] picked;
  logic [LANES*DATA_W-1:0] result;
  logic                    accept;

  lsn_src_decode #(.LANES(LANES), .ROW_LANES(ROW_LANES), .IDX_W(IDX_W)) u_dec (
    .mode(share_mode), .arg(share_arg), .src_idx(src_idx), .src_ok(src_ok)
  );

  lsn_lane_select #(.LANES(LANES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_sel (
    .src_data(src_data), .src_idx(src_idx), .picked(picked)
  );

  lsn_lane_gate #(
    .LANES(LANES), .DATA_W(DATA_W), .ROW_LANES(ROW_LANES),
    .BANK_LANES(BANK_LANES), .ROWS(ROWS), .BANKS(BANKS)
  ) u_gate (
    .picked(picked), .dst_old(dst_old), .src_ok(src_ok),
    .row_mask(row_mask), .bank_mask(bank_mask), .bound_zero(bound_zero),
    .result(result)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= result;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lsn_checker.sv
module lsn_checker #(
  parameter int W = 2048
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic [W-1:0] dst_old,
  input logic [3:0]   share_mode,
  input logic [3:0]   row_mask,
  input logic [3:0]   bank_mask,
  input logic         bound_zero
);
  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_accept_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_rows_off_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && row_mask == 4'h0 |=> out_data == $past(dst_old));

  assert_reserved_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && share_mode >= 4'd12 && !bound_zero |=> out_data == $past(dst_old));

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && share_mode >= 4'd12 && bound_zero &&
    row_mask == 4'hF && bank_mask == 4'hF |=> out_data == '0);
endmodule

bind lane_share_net lsn_checker #(.W(2048)) u_lsn_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .dst_old(dst_old), .share_mode(share_mode), .row_mask(row_mask),
  .bank_mask(bank_mask), .bound_zero(bound_zero)
);

// File: tb/lane_share_net_bench.sv
module lane_share_net_bench;
  localparam int N = 64;
  localparam int DW = 32;
  localparam int VW = N * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [VW-1:0] src_data = '0;
  logic [VW-1:0] dst_old = '0;
  logic [3:0] share_mode = '0;
  logic [7:0] share_arg = '0;
  logic [3:0] row_mask = 4'hF;
  logic [3:0] bank_mask = 4'hF;
  logic bound_zero = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [VW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lane_share_net u_lane_share_net (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_data(src_data), .dst_old(dst_old), .share_mode(share_mode),
    .share_arg(share_arg), .row_mask(row_mask), .bank_mask(bank_mask),
    .bound_zero(bound_zero), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  // Spec model: returns the expected destination vector.
  function automatic logic [VW-1:0] model(logic [VW-1:0] s, logic [VW-1:0] o,
      logic [3:0] m, logic [7:0] a, logic [3:0] rm, logic [3:0] bm, logic bz);
    logic [VW-1:0] r;
    for (int L = 0; L < N; L++) begin
      int row = L / 16;
      int p = L % 16;
      int n = a[3:0];
      int src = 0;
      bit ok = 1;
      case (m)
        4'd0:  src = 4 * (L / 4) + ((a >> (2 * (L % 4))) & 3);
        4'd1:  begin ok = (p + n <= 15); src = 16 * row + p + n; end
        4'd2:  begin ok = (p - n >= 0); src = 16 * row + p - n; end
        4'd3:  src = 16 * row + ((p - n + 16) % 16);
        4'd4:  begin ok = (L != 63); src = L + 1; end
        4'd5:  src = (L + 1) % 64;
        4'd6:  begin ok = (L != 0); src = L - 1; end
        4'd7:  src = (L + 63) % 64;
        4'd8:  src = 16 * row + 15 - p;
        4'd9:  src = 16 * row + 8 * (p / 8) + 7 - (p % 8);
        4'd10: begin ok = (row >= 1); src = 16 * row - 1; end
        4'd11: begin ok = (row >= 2); src = 31; end
        default: ok = 0;
      endcase
      if (!(rm[row] && bm[p / 4]))
        r[L*DW +: DW] = o[L*DW +: DW];
      else if (ok)
        r[L*DW +: DW] = s[src*DW +: DW];
      else if (bz)
        r[L*DW +: DW] = '0;
      else
        r[L*DW +: DW] = o[L*DW +: DW];
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < N; i++) v[i*DW +: DW] = $urandom;
    return v;
  endfunction

  task automatic check_bit(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic check_vec(string tag, logic [VW-1:0] got, logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      for (int i = 0; i < N; i++) begin
        if (got[i*DW +: DW] !== exp[i*DW +: DW]) begin
          $display("FAIL %s: lane %0d got %h expected %h", tag, i,
                   got[i*DW +: DW], exp[i*DW +: DW]);
          break;
        end
      end
    end
  endtask

  // One beat with out_ready high; result checked one cycle after acceptance.
  task automatic run(string tag, logic [3:0] m, logic [7:0] a, logic [3:0] rm,
                     logic [3:0] bm, logic bz);
    logic [VW-1:0] exp;
    @(negedge clk);
    src_data = rand_vec();
    dst_old = rand_vec();
    share_mode = m; share_arg = a; row_mask = rm; bank_mask = bm; bound_zero = bz;
    in_valid = 1'b1;
    exp = model(src_data, dst_old, m, a, rm, bm, bz);
    @(negedge clk);
    in_valid = 1'b0;
    check_bit({tag, " valid R9"}, out_valid, 1'b1);
    check_vec(tag, out_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] a_exp;
    logic [VW-1:0] b_exp;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_bit("R1 out_valid after reset", out_valid, 1'b0);
    check_bit("R1 in_ready after reset", in_ready, 1'b1);
    rst_n = 1'b1;

    run("R2 quad perm 0x1B", 4'd0, 8'h1B, 4'hF, 4'hF, 1'b0);
    run("R2 quad perm 0xE4", 4'd0, 8'hE4, 4'hF, 4'hF, 1'b0);
    run("R2 quad perm 0x00", 4'd0, 8'h00, 4'hF, 4'hF, 1'b1);
    run("R3 row mirror", 4'd8, 8'h00, 4'hF, 4'hF, 1'b0);
    run("R3 half mirror", 4'd9, 8'h00, 4'hF, 4'hF, 1'b0);
    run("R4 row shl 15 keep", 4'd1, 8'h0F, 4'hF, 4'hF, 1'b0);
    run("R4 row shl 1 zero", 4'd1, 8'h01, 4'hF, 4'hF, 1'b1);
    run("R4 row shr 15 zero", 4'd2, 8'h0F, 4'hF, 4'hF, 1'b1);
    run("R4 row shr 5 upper arg ignored", 4'd2, 8'hF5, 4'hF, 4'hF, 1'b0);
    run("R4 row ror 3", 4'd3, 8'h03, 4'hF, 4'hF, 1'b0);
    run("R4 row ror 15", 4'd3, 8'h0F, 4'hF, 4'hF, 1'b1);
    run("R4 shift amount 0", 4'd1, 8'h00, 4'hF, 4'hF, 1'b1);
    run("R5 wave shl zero", 4'd4, 8'h00, 4'hF, 4'hF, 1'b1);
    run("R5 wave shl keep", 4'd4, 8'h00, 4'hF, 4'hF, 1'b0);
    run("R5 wave rol", 4'd5, 8'h00, 4'hF, 4'hF, 1'b1);
    run("R5 wave shr zero", 4'd6, 8'h00, 4'hF, 4'hF, 1'b1);
    run("R5 wave ror", 4'd7, 8'h00, 4'hF, 4'hF, 1'b1);
    run("R6 bcast row zero", 4'd10, 8'h00, 4'hF, 4'hF, 1'b1);
    run("R6 bcast row keep", 4'd10, 8'h00, 4'hF, 4'hF, 1'b0);
    run("R6 bcast 31 zero", 4'd11, 8'h00, 4'hF, 4'hF, 1'b1);
    run("R7 rows 0,2 banks 1,3", 4'd8, 8'h00, 4'h5, 4'hA, 1'b0);
    run("R7 all rows off", 4'd3, 8'h07, 4'h0, 4'hF, 1'b1);
    run("R7 single bank", 4'd1, 8'h04, 4'hF, 4'h4, 1'b1);
    run("R8 reserved keep", 4'd12, 8'h00, 4'hF, 4'hF, 1'b0);
    run("R8 reserved zero", 4'd15, 8'h00, 4'hF, 4'hF, 1'b1);

    for (int k = 0; k < 300; k++) begin
      run("R2-R8 random", 4'($urandom), 8'($urandom), 4'($urandom),
          4'($urandom), 1'($urandom));
    end

    // R9 back-pressure: stall output, offer a second beat, then release.
    @(negedge clk);
    out_ready = 1'b0;
    src_data = rand_vec(); dst_old = rand_vec();
    share_mode = 4'd5; share_arg = 8'h00; row_mask = 4'hF; bank_mask = 4'hF;
    bound_zero = 1'b0; in_valid = 1'b1;
    a_exp = model(src_data, dst_old, 4'd5, 8'h00, 4'hF, 4'hF, 1'b0);
    @(negedge clk);
    check_bit("R9 stall valid", out_valid, 1'b1);
    check_bit("R9 stall in_ready low", in_ready, 1'b0);
    src_data = rand_vec(); dst_old = rand_vec();
    share_mode = 4'd8;
    b_exp = model(src_data, dst_old, 4'd8, 8'h00, 4'hF, 4'hF, 1'b0);
    @(negedge clk);
    check_vec("R9 stall holds first beat", out_data, a_exp);
    check_bit("R9 stall still valid", out_valid, 1'b1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_vec("R9 second beat after release", out_data, b_exp);
    @(negedge clk);
    check_bit("R9 drained", out_valid, 1'b0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule